// File: doc/BRIEF.md
# 8-bit ALU with flag generation

This block is a purely combinational 8-bit arithmetic and logic unit. It takes an operation code, an accumulator value, a second operand and the current flag byte. In the same evaluation it returns a result byte and the next flag byte. The arithmetic group covers add, add with carry, subtract, subtract with borrow, compare, increment, decrement and negate. The logic group covers AND, OR and XOR. Complement, set-carry and complement-carry complete the set.

Every operation rewrites only the flags it is defined to touch. All other bits of the flag byte are copied from the input. A surrounding datapath registers the result and the flags, and feeds the stored flag byte back in on the next operation. There is no clock and no handshake, so any change at the inputs shows at the outputs after logic delay only.

Top module: `alu8_core`

## Requirements
- R1: The flag byte holds sign at bit 7, zero at bit 6, half-carry at bit 4, parity/overflow at bit 2, subtract at bit 1 and carry at bit 0. Bits 5 and 3 of `flags_o` always equal bits 5 and 3 of `flags_i`.
- R2: ADD (code 0) returns A+B and ADC (code 1) returns A+B+carry-in. Both set sign and zero from the result. Half-carry is the carry out of bit 3, parity/overflow is signed overflow, subtract is cleared and carry is the carry out of bit 7.
- R3: SUB (code 2) returns A−B and SBC (code 3) returns A−B−carry-in. Half-carry is the borrow into bit 4, parity/overflow is signed overflow, subtract is set and carry is the borrow out of bit 7. Sign and zero come from the result.
- R4: CMP (code 4) sets all six defined flags exactly as SUB would for the same inputs, and `result_o` equals A.
- R5: NEG (code 11) returns 0−A, with the flags of a subtraction whose minuend is 0 and whose subtrahend is A.
- R6: AND (5), OR (6) and XOR (7) set sign and zero from the result and clear subtract and carry. Parity/overflow is 1 when the result has an even number of ones. Half-carry is set for AND and cleared for OR and XOR.
- R7: INC (8) returns A+1 and DEC (9) returns A−1. They update sign, zero, half-carry and overflow, leave carry unchanged, clear subtract for INC and set it for DEC. B has no effect.
- R8: CPL (10) returns the bitwise inverse of A. It sets half-carry and subtract and leaves all other flags unchanged.
- R9: SCF (12) sets carry and clears half-carry and subtract. CCF (13) inverts carry and clears subtract. Both return A, and every other flag is unchanged.
- R10: Codes 14 and 15 return A with the flag byte unchanged.
- R11: The operations in R2 to R9 that depend on a single operand ignore B. The same A, flags and code give the same outputs for any B.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code (encoding in R2 to R10) |
| acc_i | input | 8 | Accumulator operand A |
| opd_i | input | 8 | Second operand B |
| flags_i | input | 8 | Incoming flag byte |
| result_o | output | 8 | Result byte |
| flags_o | output | 8 | Updated flag byte |

## Verification
The block holds no state, so any fault in operand selection, the shared adder or the flag merge appears at the ports in the same evaluation as the stimulus. Typical visible symptoms are a wrong half-carry or overflow bit, a carry that is not inverted for subtraction, or a flag that should pass through but has been overwritten. The sweep drives every code against every accumulator value, a spread of second operands that includes the nibble and sign boundaries, and flag bytes with both carry values and varied untouched bits. A single wrong bit in any flag or result is caught on the first vector that exposes it.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBC = 4'd3,
    OP_CMP = 4'd4,
    OP_AND = 4'd5,
    OP_OR  = 4'd6,
    OP_XOR = 4'd7,
    OP_INC = 4'd8,
    OP_DEC = 4'd9,
    OP_CPL = 4'd10,
    OP_NEG = 4'd11,
    OP_SCF = 4'd12,
    OP_CCF = 4'd13
  } alu_op_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2
  } logic_fn_e;

  // flag byte bit positions (fixed: software decodes them)
  localparam int FB_S  = 7;
  localparam int FB_Z  = 6;
  localparam int FB_H  = 4;
  localparam int FB_PV = 2;
  localparam int FB_N  = 1;
  localparam int FB_C  = 0;

endpackage

// File: rtl/alu8_arith.sv
// Shared adder / subtractor. When sub is set it computes x - y - cin,
// and the carry outputs report borrows.
module alu8_arith #(
  parameter int W  = 8,
  parameter int HB = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         co,
  output logic         hc,
  output logic         ov
);
  logic [W-1:0]  y_eff;
  logic          c_eff;
  logic [W:0]    full;
  logic [HB:0]   low;

  always_comb begin
    y_eff = sub ? ~y : y;
    c_eff = sub ? ~cin : cin;
    full  = {1'b0, x} + {1'b0, y_eff} + {{W{1'b0}}, c_eff};
    low   = {1'b0, x[HB-1:0]} + {1'b0, y_eff[HB-1:0]} + {{HB{1'b0}}, c_eff};
    sum   = full[W-1:0];
    co    = full[W] ^ sub;
    hc    = low[HB] ^ sub;
    ov    = (x[W-1] == y_eff[W-1]) && (full[W-1] != x[W-1]);
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic #(
  parameter int W = 8
) (
  input  alu8_pkg::logic_fn_e fn,
  input  logic [W-1:0]        x,
  input  logic [W-1:0]        y,
  output logic [W-1:0]        res,
  output logic                even_par
);
  import alu8_pkg::*;

  always_comb begin
    case (fn)
      LG_OR:   res = x | y;
      LG_XOR:  res = x ^ y;
      default: res = x & y;
    endcase
    even_par = ~^res;
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core (
  input  logic [3:0] op_i,
  input  logic [7:0] acc_i,
  input  logic [7:0] opd_i,
  input  logic [7:0] flags_i,
  output logic [7:0] result_o,
  output logic [7:0] flags_o
);
  import alu8_pkg::*;

  localparam int W = 8;

  alu_op_e   op;
  logic [W-1:0] ax, ay;
  logic      acin, asub;
  logic [W-1:0] asum;
  logic      aco, ahc, aov;
  logic_fn_e lfn;
  logic [W-1:0] lres;
  logic      lpar;

  assign op = alu_op_e'(op_i);

  // operand steering for the shared adder
  always_comb begin
    ax   = acc_i;
    ay   = opd_i;
    acin = 1'b0;
    asub = 1'b0;
    case (op)
      OP_ADC: acin = flags_i[FB_C];
      OP_SUB, OP_CMP: asub = 1'b1;
      OP_SBC: begin
        asub = 1'b1;
        acin = flags_i[FB_C];
      end
      OP_INC: ay = {{(W-1){1'b0}}, 1'b1};
      OP_DEC: begin
        ay   = {{(W-1){1'b0}}, 1'b1};
        asub = 1'b1;
      end
      OP_NEG: begin
        ax   = '0;
        ay   = acc_i;
        asub = 1'b1;
      end
      default: ;
    endcase
  end

  always_comb begin
    case (op)
      OP_OR:   lfn = LG_OR;
      OP_XOR:  lfn = LG_XOR;
      default: lfn = LG_AND;
    endcase
  end

  alu8_arith #(.W(W), .HB(4)) u_arith (
    .x(ax), .y(ay), .cin(acin), .sub(asub),
    .sum(asum), .co(aco), .hc(ahc), .ov(aov)
  );

  alu8_logic #(.W(W)) u_logic (
    .fn(lfn), .x(acc_i), .y(opd_i), .res(lres), .even_par(lpar)
  );

  // result select and per-operation flag merge
  always_comb begin
    result_o = acc_i;
    flags_o  = flags_i;
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG, OP_CMP: begin
        if (op != OP_CMP) result_o = asum;
        flags_o[FB_S]  = asum[W-1];
        flags_o[FB_Z]  = (asum == '0);
        flags_o[FB_H]  = ahc;
        flags_o[FB_PV] = aov;
        flags_o[FB_N]  = asub;
        flags_o[FB_C]  = aco;
      end
      OP_INC, OP_DEC: begin
        result_o       = asum;
        flags_o[FB_S]  = asum[W-1];
        flags_o[FB_Z]  = (asum == '0);
        flags_o[FB_H]  = ahc;
        flags_o[FB_PV] = aov;
        flags_o[FB_N]  = asub;
      end
      OP_AND, OP_OR, OP_XOR: begin
        result_o       = lres;
        flags_o[FB_S]  = lres[W-1];
        flags_o[FB_Z]  = (lres == '0);
        flags_o[FB_H]  = (op == OP_AND);
        flags_o[FB_PV] = lpar;
        flags_o[FB_N]  = 1'b0;
        flags_o[FB_C]  = 1'b0;
      end
      OP_CPL: begin
        result_o      = ~acc_i;
        flags_o[FB_H] = 1'b1;
        flags_o[FB_N] = 1'b1;
      end
      OP_SCF: begin
        flags_o[FB_C] = 1'b1;
        flags_o[FB_H] = 1'b0;
        flags_o[FB_N] = 1'b0;
      end
      OP_CCF: begin
        flags_o[FB_C] = ~flags_i[FB_C];
        flags_o[FB_N] = 1'b0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk (
  input logic [3:0] op_i,
  input logic [7:0] acc_i,
  input logic [7:0] opd_i,
  input logic [7:0] flags_i,
  input logic [7:0] result_o,
  input logic [7:0] flags_o
);
  always_comb begin
    if (!$isunknown({op_i, acc_i, opd_i, flags_i})) begin
      p_spare_bits_r1: assert (flags_o[5] == flags_i[5] && flags_o[3] == flags_i[3]);
      if (op_i == 4'd4)
        p_cmp_keeps_acc_r4: assert (result_o == acc_i);
      if (op_i <= 4'd4)
        p_zero_matches_r2: assert (op_i == 4'd4 || flags_o[6] == (result_o == 8'h00));
      if (op_i == 4'd8 || op_i == 4'd9)
        p_incdec_carry_r7: assert (flags_o[0] == flags_i[0]);
      if (op_i >= 4'd5 && op_i <= 4'd7)
        p_logic_nc_clear_r6: assert (flags_o[1] == 1'b0 && flags_o[0] == 1'b0);
      if (op_i == 4'd5 && opd_i == 8'h00)
        p_and_zero_r6: assert (result_o == 8'h00 && flags_o[6]);
      if (op_i == 4'd10)
        p_cpl_invert_r8: assert (result_o == ~acc_i && flags_o[0] == flags_i[0]
                                 && flags_o[2] == flags_i[2] && flags_o[7:6] == flags_i[7:6]);
      if (op_i == 4'd12)
        p_scf_carry_r9: assert (flags_o[0] && !flags_o[1] && !flags_o[4]);
      if (op_i >= 4'd14)
        p_unused_code_r10: assert (result_o == acc_i && flags_o == flags_i);
    end
  end
endmodule

bind alu8_core alu8_core_chk u_chk (.*);

// File: tb/alu8_core_test.sv
module alu8_core_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic [3:0] op;
  logic [7:0] a, b, fi, r, fo;
  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  alu8_core uut (
    .op_i(op), .acc_i(a), .opd_i(b), .flags_i(fi),
    .result_o(r), .flags_o(fo)
  );

  function automatic int sx(input int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  function automatic string tag(input int o);
    case (o)
      0, 1:    return "R2";
      2, 3:    return "R3";
      4:       return "R4";
      5, 6, 7: return "R6";
      8, 9:    return "R7";
      10:      return "R8";
      11:      return "R5";
      12, 13:  return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic model(input int o, input int av, input int bv, input logic [7:0] f,
                       output logic [7:0] er, output logic [7:0] ef);
    int c, t, h, sv, x, y, k, ones;
    c  = int'(f[0]);
    er = av[7:0];
    ef = f;
    case (o)
      0, 1: begin
        k = (o == 1) ? c : 0;
        t = av + bv + k; h = (av % 16) + (bv % 16) + k; sv = sx(av) + sx(bv) + k;
        er = t[7:0];
        ef[7] = er[7]; ef[6] = (er == 0); ef[4] = (h > 15);
        ef[2] = (sv > 127 || sv < -128); ef[1] = 0; ef[0] = (t > 255);
      end
      2, 3, 4, 11: begin
        x = (o == 11) ? 0 : av; y = (o == 11) ? av : bv; k = (o == 3) ? c : 0;
        t = x - y - k; h = (x % 16) - (y % 16) - k; sv = sx(x) - sx(y) - k;
        er = t[7:0];
        ef[7] = er[7]; ef[6] = (er == 0); ef[4] = (h < 0);
        ef[2] = (sv > 127 || sv < -128); ef[1] = 1; ef[0] = (t < 0);
        if (o == 4) er = av[7:0];
      end
      5, 6, 7: begin
        er = (o == 5) ? (av[7:0] & bv[7:0]) : (o == 6) ? (av[7:0] | bv[7:0]) : (av[7:0] ^ bv[7:0]);
        ones = 0;
        for (int i = 0; i < 8; i++) ones += int'(er[i]);
        ef[7] = er[7]; ef[6] = (er == 0); ef[4] = (o == 5);
        ef[2] = (ones % 2 == 0); ef[1] = 0; ef[0] = 0;
      end
      8: begin
        t = av + 1; er = t[7:0];
        ef[7] = er[7]; ef[6] = (er == 0); ef[4] = (av % 16 == 15);
        ef[2] = (av == 127); ef[1] = 0;
      end
      9: begin
        t = av + 255; er = t[7:0];
        ef[7] = er[7]; ef[6] = (er == 0); ef[4] = (av % 16 == 0);
        ef[2] = (av == 128); ef[1] = 1;
      end
      10: begin er = ~av[7:0]; ef[4] = 1; ef[1] = 1; end
      12: begin ef[0] = 1; ef[4] = 0; ef[1] = 0; end
      13: begin ef[0] = ~f[0]; ef[1] = 0; end
      default: ;
    endcase
  endtask

  task automatic check(input string req, input logic [7:0] got_r, input logic [7:0] got_f,
                       input logic [7:0] exp_r, input logic [7:0] exp_f);
    checks++;
    if (got_r !== exp_r || got_f !== exp_f) begin
      fails++;
      if (fails <= 20)
        $display("FAIL %s op=%0d a=%02h b=%02h f=%02h: actual r=%02h f=%02h expected r=%02h f=%02h",
                 req, op, a, b, fi, got_r, got_f, exp_r, exp_f);
    end
  endtask

  function automatic logic [7:0] bpick(input int i);
    case (i)
      0: return 8'h00;  1: return 8'h01;  2: return 8'h0F;  3: return 8'h10;
      4: return 8'h7F;  5: return 8'h80;  6: return 8'hFF;  7: return 8'h55;
      8: return 8'hAA;  9: return 8'h08;  10: return 8'h3C; 11: return 8'hC3;
      12: return 8'h81; 13: return 8'h7E; 14: return 8'hF0; default: return 8'h26;
    endcase
  endfunction

  initial begin
    logic [7:0] er, ef, r0, f0;
    // zero-input state: ADD of zeros gives zero with only Z set (R2)
    op = 4'd0; a = 8'h00; b = 8'h00; fi = 8'h00;
    @(negedge clk);
    check("R2", r, fo, 8'h00, 8'h40);
    // full sweep: every code, every A, boundary B values, both carries
    for (int o = 0; o < 16; o++) begin
      for (int av = 0; av < 256; av++) begin
        for (int bi = 0; bi < 16; bi++) begin
          for (int c = 0; c < 2; c++) begin
            op = o[3:0]; a = av[7:0]; b = bpick(bi);
            fi = ((8'(bi) * 8'd53) ^ av[7:0] ^ 8'h28) & 8'hFE | {7'd0, c[0]};
            #1;
            model(o, av, int'(b), fi, er, ef);
            check(tag(o), r, fo, er, ef);
            // R1: untouched spare bits
            check("R1", 8'h00, fo & 8'h28, 8'h00, fi & 8'h28);
          end
        end
      end
    end
    // R11: single-operand codes give identical outputs for different B
    for (int o = 8; o < 14; o++) begin
      op = o[3:0]; a = 8'h9D; fi = 8'hD5; b = 8'h00; #1;
      r0 = r; f0 = fo;
      b = 8'hE7; #1;
      check("R11", r, fo, r0, f0);
    end
    done = 1'b1;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (done || cycles > 150000) begin
      if (!done) begin
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule